// File: doc/BRIEF.md
# Accumulator Logic, Rotate and Flag Unit

This block carries out the bitwise, compare, rotate and carry-manipulation operations of a small accumulator-based processor datapath. Each cycle in which a request is presented, it takes an operation code, the accumulator value, an operand value and the processor's current five-flag word. It computes the new accumulator value, a write-enable that tells the register file whether the accumulator should take that value, and the new flag word. Every operation has its own rule for which flags it recomputes and which it passes through unchanged.

All three results are registered and appear one clock after the request. The surrounding pipeline feeds the registered flag word back as the next request's flag input. Arithmetic add and subtract, register-file access and memory addressing are handled elsewhere.

Top module: `acc_logic_flag_unit`

## Requirements
- R1: The results are registered and appear one cycle after a request with `op_valid` high. Reset clears `acc_out`, `acc_we` and `flags_out` to zero. A cycle with `op_valid` low drives `acc_we` low and leaves `acc_out` and `flags_out` unchanged. The flag word is packed as bit 4 sign (S), bit 3 zero (Z), bit 2 auxiliary carry (AC), bit 1 parity (P) and bit 0 carry (CY).
- R2: Code 0 (AND) writes `acc_in & opnd_in`. It recomputes S, Z and P from that result, clears CY and sets AC.
- R3: Code 1 (XOR) writes `acc_in ^ opnd_in`, and code 2 (OR) writes `acc_in | opnd_in`. Both recompute S, Z and P from the result and clear both CY and AC.
- R4: Code 3 (compare) does not write: `acc_we` is low and `acc_out` shows `acc_in`. CY is set when `acc_in < opnd_in` (unsigned). Z is set when the two are equal. S and P come from the discarded difference `acc_in - opnd_in`. AC is set when the low four bits of `acc_in` are below the low four bits of `opnd_in`.
- R5: Code 4 rotates left: the MSB goes to both bit 0 and CY. Code 5 rotates right: bit 0 goes to both the MSB and CY. Both write the accumulator.
- R6: Code 6 rotates left through carry: the MSB goes to CY and the old CY goes to bit 0. Code 7 rotates right through carry: bit 0 goes to CY and the old CY goes to the MSB. Both write the accumulator.
- R7: The four rotates (codes 4 to 7) pass S, Z, AC and P through from `flags_in` unchanged.
- R8: Code 8 writes `~acc_in` and passes all five flags through unchanged.
- R9: Code 9 inverts CY, and code 10 sets CY. Neither writes the accumulator (`acc_out` shows `acc_in`), and both pass S, Z, AC and P through unchanged.
- R10: Wherever S, Z and P are recomputed, S equals the MSB of the value, Z is 1 exactly when the value is zero, and P is 1 exactly when the value has an even number of one bits.
- R11: Codes 11 to 15 do not write (`acc_out` shows `acc_in`) and pass all flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A request is present this cycle |
| op_sel | input | 4 | Operation code |
| acc_in | input | W | Current accumulator |
| opnd_in | input | W | Operand |
| flags_in | input | 5 | Current flags {S,Z,AC,P,CY} |
| acc_out | output | W | Registered new accumulator value |
| acc_we | output | 1 | Registered accumulator write-enable |
| flags_out | output | 5 | Registered new flags {S,Z,AC,P,CY} |

## Verification
Every result of this block (the accumulator value, the write-enable and all five flags) is due exactly one rising edge after the request that produced it. No operation takes longer. The bench drives each request on a falling edge and compares all three outputs on the following falling edge. That point is half a period after the single register stage has loaded, and it is also when the next request is driven. Cycles with `op_valid` low are checked at the same point against the values held from the previous request.

// File: rtl/acl_pkg.sv
package acl_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,
      OP_XOR = 4'd1,
      OP_OR  = 4'd2,
      OP_CMP = 4'd3,
      OP_ROL = 4'd4,
      OP_ROR = 4'd5,
      OP_RCL = 4'd6,
      OP_RCR = 4'd7,
      OP_CPL = 4'd8,
      OP_CMC = 4'd9,
      OP_STC = 4'd10
   } acl_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } acl_flags_t;

   localparam int unsigned FLAG_BITS = $bits(acl_flags_t);

endpackage

// File: rtl/acl_parity.sv
module acl_parity #(
   parameter int unsigned W        = 8,
   parameter bit          PAR_TREE = 1'b1
) (
   input  logic [W-1:0] val,
   output logic         even
);
   generate
      if (PAR_TREE) begin : g_tree
         assign even = ~(^val);
      end else begin : g_chain
         always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < int'(W); i++) acc = acc ^ val[i];
            even = ~acc;
         end
      end
   endgenerate
endmodule

// File: rtl/acl_logic.sv
module acl_logic
   import acl_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter int unsigned NIB    = 4
) (
   input  acl_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] bit_res,
   output logic [W-1:0] diff,
   output logic         borrow,
   output logic         nib_borrow
);
   logic [W:0] wide_diff;

   always_comb begin
      unique case (op)
         OP_AND:  bit_res = a & b;
         OP_XOR:  bit_res = a ^ b;
         OP_OR:   bit_res = a | b;
         default: bit_res = a & b;
      endcase
   end

   assign wide_diff  = {1'b0, a} - {1'b0, b};
   assign diff       = wide_diff[W-1:0];
   assign borrow     = wide_diff[W];
   assign nib_borrow = (a[NIB-1:0] < b[NIB-1:0]);
endmodule

// File: rtl/acl_rotate.sv
module acl_rotate
   import acl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  acl_op_e      op,
   input  logic [W-1:0] a,
   input  logic         cy_in,
   output logic [W-1:0] rot,
   output logic         cy_out
);
   always_comb begin
      rot    = a;
      cy_out = cy_in;
      case (op)
         OP_ROL: begin rot = {a[W-2:0], a[W-1]}; cy_out = a[W-1]; end
         OP_ROR: begin rot = {a[0], a[W-1:1]};   cy_out = a[0];   end
         OP_RCL: begin rot = {a[W-2:0], cy_in};  cy_out = a[W-1]; end
         OP_RCR: begin rot = {cy_in, a[W-1:1]};  cy_out = a[0];   end
         default: ;
      endcase
   end
endmodule

// File: rtl/acl_flags.sv
module acl_flags
   import acl_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter bit          PAR_TREE = 1'b1
) (
   input  acl_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] bit_res,
   input  logic [W-1:0] diff,
   input  logic         borrow,
   input  logic         nib_borrow,
   input  logic [W-1:0] rot,
   input  logic         rot_cy,
   input  acl_flags_t   f_in,
   output logic [W-1:0] res,
   output logic         we,
   output acl_flags_t   f_out
);
   logic par_bit, par_diff;

   acl_parity #(.W(W), .PAR_TREE(PAR_TREE)) u_par_bit  (.val(bit_res), .even(par_bit));
   acl_parity #(.W(W), .PAR_TREE(PAR_TREE)) u_par_diff (.val(diff),    .even(par_diff));

   always_comb begin
      f_out = f_in;
      we    = 1'b0;
      res   = a;
      case (op)
         OP_AND, OP_XOR, OP_OR: begin
            we       = 1'b1;
            res      = bit_res;
            f_out.s  = bit_res[W-1];
            f_out.z  = (bit_res == '0);
            f_out.p  = par_bit;
            f_out.cy = 1'b0;
            f_out.ac = (op == OP_AND);
         end
         OP_CMP: begin
            f_out.s  = diff[W-1];
            f_out.z  = (diff == '0);
            f_out.p  = par_diff;
            f_out.cy = borrow;
            f_out.ac = nib_borrow;
         end
         OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
            we       = 1'b1;
            res      = rot;
            f_out.cy = rot_cy;
         end
         OP_CPL: begin
            we  = 1'b1;
            res = ~a;
         end
         OP_CMC: f_out.cy = ~f_in.cy;
         OP_STC: f_out.cy = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_logic_flag_unit.sv
module acc_logic_flag_unit
   import acl_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter bit          PAR_TREE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [3:0]   op_sel,
   input  logic [W-1:0] acc_in,
   input  logic [W-1:0] opnd_in,
   input  logic [4:0]   flags_in,
   output logic [W-1:0] acc_out,
   output logic         acc_we,
   output logic [4:0]   flags_out
);
   localparam int unsigned NIB = 4;

   generate
      if (W <= NIB) begin : g_bad_width
         $error("acc_logic_flag_unit: W must exceed the nibble width");
      end
      if (FLAG_BITS != 5) begin : g_bad_flags
         $error("acc_logic_flag_unit: flag word must be five bits");
      end
   endgenerate

   acl_op_e    op;
   acl_flags_t f_cur, f_nxt;
   logic [W-1:0] bit_res, diff, rot, res_nxt;
   logic borrow, nib_borrow, rot_cy, we_nxt;

   assign op    = acl_op_e'(op_sel);
   assign f_cur = acl_flags_t'(flags_in);

   acl_logic #(.W(W), .NIB(NIB)) u_logic (
      .op(op), .a(acc_in), .b(opnd_in), .bit_res(bit_res),
      .diff(diff), .borrow(borrow), .nib_borrow(nib_borrow)
   );

   acl_rotate #(.W(W)) u_rot (
      .op(op), .a(acc_in), .cy_in(f_cur.cy), .rot(rot), .cy_out(rot_cy)
   );

   acl_flags #(.W(W), .PAR_TREE(PAR_TREE)) u_flags (
      .op(op), .a(acc_in), .bit_res(bit_res), .diff(diff), .borrow(borrow),
      .nib_borrow(nib_borrow), .rot(rot), .rot_cy(rot_cy), .f_in(f_cur),
      .res(res_nxt), .we(we_nxt), .f_out(f_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_out   <= '0;
         acc_we    <= 1'b0;
         flags_out <= '0;
      end else if (op_valid) begin
         acc_out   <= res_nxt;
         acc_we    <= we_nxt;
         flags_out <= f_nxt;
      end else begin
         acc_we    <= 1'b0;
      end
   end
endmodule

// File: rtl/acc_logic_flag_unit_chk.sv
module acc_logic_flag_unit_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [3:0]   op_sel,
   input logic [W-1:0] acc_in,
   input logic [W-1:0] opnd_in,
   input logic [4:0]   flags_in,
   input logic [W-1:0] acc_out,
   input logic         acc_we,
   input logic [4:0]   flags_out
);
   a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !acc_we);
   a_r1_idle_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flags_out));
   a_r2_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 4'd0) |=> (flags_out[2] && !flags_out[0] && acc_we));
   a_r3_orxor_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == 4'd1 || op_sel == 4'd2)) |=> (!flags_out[2] && !flags_out[0]));
   a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 4'd3) |=> (!acc_we && acc_out == $past(acc_in)));
   a_r7_rot_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel[3:2] == 2'b01) |=> (flags_out[4:1] == $past(flags_in[4:1])));
   a_r8_cpl_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 4'd8) |=> (flags_out == $past(flags_in)));
   a_r9_stc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 4'd10) |=> (flags_out[0] && !acc_we));
   a_r11_unused: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel > 4'd10) |=> (!acc_we && flags_out == $past(flags_in)));
endmodule

bind acc_logic_flag_unit acc_logic_flag_unit_chk #(.W(W)) chk_i (.*);

// File: tb/acc_logic_flag_unit_tb_top.sv
module acc_logic_flag_unit_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_sel = '0;
   logic [W-1:0] acc_in = '0, opnd_in = '0;
   logic [4:0]   flags_in = '0;
   logic [W-1:0] acc_out;
   logic         acc_we;
   logic [4:0]   flags_out;

   int n_tests = 0, n_fail = 0;
   logic [W-1:0] exp_res = '0;
   logic [4:0]   exp_flags = '0;

   always #2.5 clk = ~clk;

   acc_logic_flag_unit #(.W(W)) dut_i (.*);

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R2 R10";
         4'd1, 4'd2: return "R3 R10";
         4'd3: return "R4 R10";
         4'd4, 4'd5: return "R5 R7";
         4'd6, 4'd7: return "R6 R7";
         4'd8: return "R8";
         4'd9, 4'd10: return "R9";
         default: return "R11";
      endcase
   endfunction

   // returns {we, res, flags}
   function automatic logic [W+5:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                          input logic [W-1:0] b, input logic [4:0] f);
      logic [W-1:0] r; logic [4:0] o; logic w; logic [W:0] d;
      r = a; o = f; w = 1'b0;
      d = {1'b0, a} - {1'b0, b};
      case (op)
         4'd0, 4'd1, 4'd2: begin
            r = (op == 0) ? (a & b) : (op == 1) ? (a ^ b) : (a | b);
            w = 1'b1;
            o = {r[W-1], r == 0, op == 0, ~(^r), 1'b0};
         end
         4'd3: o = {d[W-1], a == b, a[3:0] < b[3:0], ~(^d[W-1:0]), a < b};
         4'd4: begin r = {a[W-2:0], a[W-1]}; w = 1; o[0] = a[W-1]; end
         4'd5: begin r = {a[0], a[W-1:1]};   w = 1; o[0] = a[0];   end
         4'd6: begin r = {a[W-2:0], f[0]};   w = 1; o[0] = a[W-1]; end
         4'd7: begin r = {f[0], a[W-1:1]};   w = 1; o[0] = a[0];   end
         4'd8: begin r = ~a; w = 1; end
         4'd9: o[0] = ~f[0];
         4'd10: o[0] = 1'b1;
         default: ;
      endcase
      return {w, r, o};
   endfunction

   task automatic check(input string tag, input logic [W-1:0] er, input logic ew, input logic [4:0] ef);
      n_tests++;
      if (acc_out !== er || acc_we !== ew || flags_out !== ef) begin
         n_fail++;
         $display("FAIL %s: got res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
                  tag, acc_out, acc_we, flags_out, er, ew, ef);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [4:0] f);
      logic [W+5:0] m;
      op_valid = 1'b1; op_sel = op; acc_in = a; opnd_in = b; flags_in = f;
      m = model(op, a, b, f);
      @(negedge clk);
      exp_res = m[W+4:5]; exp_flags = m[4:0];
      check(tag_of(op), exp_res, m[W+5], exp_flags);
   endtask

   task automatic idle(input logic [W-1:0] a, input logic [4:0] f);
      op_valid = 1'b0; op_sel = 4'd0; acc_in = a; flags_in = f;
      @(negedge clk);
      check("R1 idle", exp_res, 1'b0, exp_flags);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0085));
      @(negedge clk); @(negedge clk);
      check("R1 reset", '0, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", '0, 1'b0, '0);
      // directed corners
      apply(4'd0, 8'hF0, 8'h0F, 5'b00001);      // R2 zero result
      apply(4'd0, 8'hFF, 8'h81, 5'b00000);
      apply(4'd1, 8'hAA, 8'hAA, 5'b00101);      // R3
      apply(4'd2, 8'h01, 8'h02, 5'b11111);
      apply(4'd3, 8'h42, 8'h42, 5'b00000);      // R4 equal
      apply(4'd3, 8'h10, 8'h21, 5'b00000);      // less
      apply(4'd3, 8'hF0, 8'h01, 5'b11111);      // greater
      apply(4'd4, 8'h80, 8'h00, 5'b10110);      // R5
      apply(4'd5, 8'h01, 8'h00, 5'b01000);
      apply(4'd6, 8'h80, 8'h00, 5'b00001);      // R6
      apply(4'd6, 8'h00, 8'h00, 5'b00001);
      apply(4'd7, 8'h01, 8'h00, 5'b11110);
      apply(4'd7, 8'h00, 8'h00, 5'b00001);
      apply(4'd8, 8'h5A, 8'h00, 5'b10101);      // R8
      apply(4'd9, 8'h33, 8'h00, 5'b11111);      // R9
      apply(4'd10, 8'h33, 8'h00, 5'b11110);
      apply(4'd13, 8'h77, 8'h12, 5'b01010);     // R11
      idle(8'hC3, 5'b10101);                    // R1 hold
      idle(8'h00, 5'b00000);
      for (int i = 0; i < 30000; i++) begin
         if (($urandom % 8) == 0) idle($urandom, $urandom);
         else apply($urandom, $urandom, $urandom, $urandom);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule